// File: doc/BRIEF.md
# Parallel Test Compression Datapath

This block is the data path between the single-bit pin-side data input/output of a one-bit-wide memory and the eight-bit-wide internal array port behind it. The array stores eight bits per internal word, one bit per sector. A three-bit sector select, taken from address bits, picks which of those eight bits a one-bit access touches.

In normal mode, a write enables only the selected sector lane, and a read returns the selected lane's bit. In test mode, set by the cycle decoder, the sector select is ignored. A write drives the input bit into all eight lanes at once. A read returns a pass/fail flag instead of stored data: 1 when the eight bits read back are identical, 0 when any of them differs. This lets the memory be exercised as a device one eighth the size, and a single bad sector shows up as a 0.

The compare is combinational on the eight-bit read word. Its result is captured in the same output register as normal read data, so both modes have the same read latency.

Top module: `tcmp_datapath`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `dout` is 0, whatever was read before the reset.
- R2: In normal mode (`test_mode`=0), with `wr_req`=1, `arr_we` has exactly one bit set, at index `sector_addr`. The three select bits are ordered {row top bit, column top bit, column bit 0}, so lane index = 4*row_top + 2*col_top + col_bit0.
- R3: In test mode (`test_mode`=1), with `wr_req`=1, all eight bits of `arr_we` are set for every value of `sector_addr`.
- R4: `arr_wdata` carries `din` on every lane in both modes.
- R5: With `wr_req`=0, `arr_we` is all zeros.
- R6: In normal mode, a cycle with `rd_req`=1 makes `dout` equal `arr_rdata[sector_addr]` one clock later.
- R7: In test mode, a cycle with `rd_req`=1 and `arr_rdata` equal to 8'h00 or 8'hFF makes `dout` 1 one clock later.
- R8: In test mode, a cycle with `rd_req`=1 and `arr_rdata` holding at least one bit that differs from the others makes `dout` 0 one clock later. A single corrupted sector is enough.
- R9: In test mode, the value of `sector_addr` has no effect on the read result.
- R10: `dout` keeps its value in every cycle with `rd_req`=0, even when `arr_rdata`, `sector_addr` or `test_mode` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | 1 = compressed test mode, 0 = normal mode (from the cycle decoder) |
| sector_addr | input | 3 | Sector select {row top bit, column top bit, column bit 0} |
| wr_req | input | 1 | Write strobe for the current cycle |
| rd_req | input | 1 | Read capture strobe for the current cycle |
| din | input | 1 | Pin-side data in |
| arr_we | output | 8 | Per-lane write enables to the array |
| arr_wdata | output | 8 | Per-lane write data to the array |
| arr_rdata | input | 8 | Eight-bit word read from the array |
| dout | output | 1 | Registered pin-side data out |

## Verification
Normal reads use words with a single one or a single zero in the selected lane, so that a select that is off by one, or uses the wrong bit order, returns the wrong value. Test-mode reads cover both uniform words (all zeros, all ones), which must pass. They also cover words with one corrupted lane at the low end, the high end and the middle, and a mixed pattern, which must all fail. The failing cases catch a compare that skips a lane or only looks at one polarity. Sweeping every sector select over a passing and a failing test-mode word shows the select does not leak into the compressed result. A hold window with a changing array word shows that `dout` updates only on read strobes.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam int unsigned TCMP_LANES = 8;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_TEST   = 1'b1
  } tcmp_mode_e;
endpackage

// File: rtl/tcmp_lane_dec.sv
module tcmp_lane_dec
  import tcmp_pkg::*;
#(
  parameter int unsigned LANES = TCMP_LANES,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  logic             wr_req,
  input  tcmp_mode_e       mode,
  input  logic [SEL_W-1:0] sel,
  output logic [LANES-1:0] we
);
  // A lane is enabled when it is the selected one, or on any lane in test mode.
  function automatic logic lane_hit(input tcmp_mode_e m, input logic [SEL_W-1:0] s,
                                    input int unsigned idx);
    return (m == MODE_TEST) || (s == SEL_W'(idx));
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign we[g] = wr_req & lane_hit(mode, sel, g);
  end
endmodule

// File: rtl/tcmp_compress.sv
module tcmp_compress
  import tcmp_pkg::*;
#(
  parameter int unsigned LANES = TCMP_LANES
) (
  input  logic [LANES-1:0] word,
  output logic             all_same
);
  // Every lane is compared with lane 0; any mismatch clears the flag.
  logic [LANES-2:0] mismatch;

  for (genvar g = 1; g < LANES; g++) begin : g_cmp
    assign mismatch[g-1] = word[g] ^ word[0];
  end

  assign all_same = ~|mismatch;
endmodule

// File: rtl/tcmp_rd_sel.sv
module tcmp_rd_sel
  import tcmp_pkg::*;
#(
  parameter int unsigned LANES = TCMP_LANES,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] word,
  input  logic [SEL_W-1:0] sel,
  output logic             bit_out
);
  assign bit_out = word[sel];
endmodule

// File: rtl/tcmp_datapath.sv
module tcmp_datapath
  import tcmp_pkg::*;
#(
  parameter int unsigned LANES = TCMP_LANES,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_mode,
  input  logic [SEL_W-1:0] sector_addr,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic             din,
  output logic [LANES-1:0] arr_we,
  output logic [LANES-1:0] arr_wdata,
  input  logic [LANES-1:0] arr_rdata,
  output logic             dout
);
  tcmp_mode_e mode;
  logic       lane_bit;    // normal-mode selected bit
  logic       cmp_equal;   // test-mode compression flag
  logic       rd_next;     // value captured on a read strobe
  logic       dout_q;

  assign mode = tcmp_mode_e'(test_mode);

  tcmp_lane_dec #(.LANES(LANES)) u_lane_dec (
    .wr_req (wr_req),
    .mode   (mode),
    .sel    (sector_addr),
    .we     (arr_we)
  );

  assign arr_wdata = {LANES{din}};

  tcmp_rd_sel #(.LANES(LANES)) u_rd_sel (
    .word    (arr_rdata),
    .sel     (sector_addr),
    .bit_out (lane_bit)
  );

  tcmp_compress #(.LANES(LANES)) u_compress (
    .word     (arr_rdata),
    .all_same (cmp_equal)
  );

  assign rd_next = (mode == MODE_TEST) ? cmp_equal : lane_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)      dout_q <= 1'b0;
    else if (rd_req) dout_q <= rd_next;
  end

  assign dout = dout_q;
endmodule

// File: rtl/tcmp_datapath_chk.sv
module tcmp_datapath_chk #(
  parameter int unsigned LANES = 8,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_mode,
  input logic [SEL_W-1:0] sector_addr,
  input logic             wr_req,
  input logic             rd_req,
  input logic             din,
  input logic [LANES-1:0] arr_we,
  input logic [LANES-1:0] arr_wdata,
  input logic [LANES-1:0] arr_rdata,
  input logic             dout
);
  logic sel_bit;
  logic uniform;
  assign sel_bit = arr_rdata[sector_addr];
  assign uniform = (arr_rdata == '0) || (arr_rdata == '1);

  AST_NORM_WE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !test_mode) |-> ($onehot(arr_we) && arr_we[sector_addr])); // R2
  AST_TEST_WE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && test_mode) |-> (arr_we == '1)); // R3
  AST_WDATA_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wdata == {LANES{din}})); // R4
  AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |-> (arr_we == '0)); // R5
  AST_NORM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !test_mode) |=> (dout == $past(sel_bit))); // R6
  AST_TEST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && test_mode && uniform) |=> dout); // R7
  AST_TEST_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && test_mode && !uniform) |=> !dout); // R8
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(dout)); // R10
endmodule

bind tcmp_datapath tcmp_datapath_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .sector_addr(sector_addr),
  .wr_req(wr_req), .rd_req(rd_req), .din(din), .arr_we(arr_we),
  .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .dout(dout)
);

// File: tb/tb_tcmp_datapath.sv
module tb_tcmp_datapath;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       test_mode = 1'b0;
  logic [2:0] sector_addr = '0;
  logic       wr_req = 1'b0;
  logic       rd_req = 1'b0;
  logic       din = 1'b0;
  logic [7:0] arr_we, arr_wdata, arr_rdata;
  logic       dout;

  logic       pre_en = 1'b0;
  logic [7:0] pre_val = '0;
  logic [7:0] mem = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;   // 125 MHz

  tcmp_datapath dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .sector_addr(sector_addr),
    .wr_req(wr_req), .rd_req(rd_req), .din(din), .arr_we(arr_we),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .dout(dout)
  );

  // Simple one-word array model: bench preload or per-lane writes.
  always_ff @(posedge clk) begin
    if (pre_en) mem <= pre_val;
    else
      for (int i = 0; i < 8; i++)
        if (arr_we[i]) mem[i] <= arr_wdata[i];
  end
  assign arr_rdata = mem;

  // {test, sel[2:0], word[7:0], expected dout}
  localparam logic [12:0] VEC [12] = '{
    {1'b0, 3'd0, 8'h01, 1'b1},
    {1'b0, 3'd7, 8'h80, 1'b1},
    {1'b0, 3'd3, 8'hF7, 1'b0},
    {1'b0, 3'd5, 8'h20, 1'b1},
    {1'b0, 3'd6, 8'hBF, 1'b0},
    {1'b1, 3'd0, 8'h00, 1'b1},
    {1'b1, 3'd5, 8'hFF, 1'b1},
    {1'b1, 3'd2, 8'hFE, 1'b0},
    {1'b1, 3'd7, 8'h7F, 1'b0},
    {1'b1, 3'd3, 8'h10, 1'b0},
    {1'b1, 3'd6, 8'hA5, 1'b0},
    {1'b0, 3'd2, 8'h04, 1'b1}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_word(input logic [7:0] v);
    @(negedge clk); pre_en = 1'b1; pre_val = v;
    @(negedge clk); pre_en = 1'b0;
  endtask

  task automatic do_read(input logic t, input logic [2:0] s);
    @(negedge clk); rd_req = 1'b1; test_mode = t; sector_addr = s;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic do_write(input logic t, input logic [2:0] s, input logic d,
                          input logic [7:0] exp_we, input string tag);
    @(negedge clk); wr_req = 1'b1; test_mode = t; sector_addr = s; din = d;
    #1;
    check(tag, arr_we, exp_we);
    check("R4", arr_wdata, {8{d}});
    @(negedge clk); wr_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {7'd0, dout}, 8'd0);
    rst_n = 1'b1;

    for (int k = 0; k < 12; k++) begin
      set_word(VEC[k][8:1]);
      do_read(VEC[k][12], VEC[k][11:9]);
      if (!VEC[k][12])  check("R6", {7'd0, dout}, {7'd0, VEC[k][0]});
      else if (VEC[k][0]) check("R7", {7'd0, dout}, 8'd1);
      else              check("R8", {7'd0, dout}, 8'd0);
    end

    // R5: idle cycle, no lane written
    @(negedge clk); wr_req = 1'b0; test_mode = 1'b1; #1;
    check("R5", arr_we, 8'h00);

    // R2: normal write of lane 5 into a zero word
    set_word(8'h00);
    do_write(1'b0, 3'd5, 1'b1, 8'h20, "R2");
    do_read(1'b0, 3'd5); check("R2", {7'd0, dout}, 8'd1);
    do_read(1'b0, 3'd4); check("R2", {7'd0, dout}, 8'd0);

    // R3: test write of 0 into an all-ones word clears every lane
    set_word(8'hFF);
    do_write(1'b1, 3'd3, 1'b0, 8'hFF, "R3");
    do_read(1'b1, 3'd6); check("R7", {7'd0, dout}, 8'd1);
    do_read(1'b0, 3'd1); check("R3", {7'd0, dout}, 8'd0);

    // R8: test write of 1, then one corrupted sector
    do_write(1'b1, 3'd0, 1'b1, 8'hFF, "R3");
    do_read(1'b1, 3'd4); check("R7", {7'd0, dout}, 8'd1);
    set_word(8'hEF);
    do_read(1'b1, 3'd4); check("R8", {7'd0, dout}, 8'd0);

    // R9: select has no effect in test mode
    for (int s = 0; s < 8; s++) begin
      set_word(8'hFF);
      do_read(1'b1, 3'(s)); check("R9", {7'd0, dout}, 8'd1);
      set_word(8'hFB);
      do_read(1'b1, 3'(s)); check("R9", {7'd0, dout}, 8'd0);
    end

    // R10: dout holds without a read strobe
    set_word(8'hFF);
    do_read(1'b0, 3'd2);
    set_word(8'h00);
    @(negedge clk); sector_addr = 3'd6; test_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", {7'd0, dout}, 8'd1);

    // R1: reset clears a captured 1
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {7'd0, dout}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {7'd0, dout}, 8'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end
endmodule